// File: doc/BRIEF.md
# Partitioned Inter-Processor Interrupt Unit

This block lets cores signal one another. Every core owns a 16-bit cause register. Software on any core can raise one cause bit on a group of target cores with a single bus write. Each target core then acknowledges its own causes by writing ones to its cause register, which clears them.

The 16 cause bits of a core fold into four fixed classes: bit 0 alone, bits 1 to 3, bits 4 to 7, and bits 8 to 15. A class is active when any of its bits is set. A shared partition register holds one 2-bit steering field per class. The field chooses which of three interrupt levels that class drives on every core. A field value of 3 silences its class.

The unit sits on a simple register bus that has a single write port. Reads come back combinationally from the address. The output is a 3-bit level vector per core and depends only on stored state. Merging these levels with other interrupt sources is left to the surrounding logic.

Top module: `ipi_unit`

## Requirements
- R1: A write of a core bitmask to address 0x140+k, with k from 0 to 15, sets cause bit k of every core c whose mask bit c is 1. All other cause bits are left unchanged.
- R2: Address 0x100+c reads core c's cause register in bits [15:0], with bits [31:16] read as zero. Writing to that address clears each cause bit whose data bit in [15:0] is 1, and data bits [31:16] have no effect.
- R3: Class activity of a core is defined as follows. Class 0 is cause bit 0. Class 1 is the OR of bits 3:1. Class 2 is the OR of bits 7:4. Class 3 is the OR of bits 15:8.
- R4: Steering is set by the partition register at 0x190. Bits [1:0] steer class 0, [3:2] steer class 1, [5:4] steer class 2 and [7:6] steer class 3. Core c's level output bit n is 1 when at least one active class has a field equal to n. A field of 3 drives nothing.
- R5: The partition register reads back all 32 bits as last written. Bits [31:8] have no effect on any output.
- R6: While reset is asserted, every cause register and the partition register are zero, and so every level output is zero.
- R7: Writes to 0x150 through 0x15F (k of 16 or more) are ignored. So are writes to cause addresses 0x100+c with c not smaller than NUM_CORES, such as 0x120. Reads of any unmapped address return zero.
- R8: The level outputs change only in the cycle after a register write. A write is visible at the outputs right after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | ADDR_W | Register address for writes and reads |
| reg_wdata | input | 32 | Write data: a core mask for set writes, clear bits for cause writes, the value for partition writes |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ipi_lvl | output | NUM_CORES*3 | Level outputs, core c in bits [3c+2:3c] |

## Verification
Set writes are tried with sparse masks that include the first and last core, and with the lowest and highest cause index. These show whether the mask is decoded per core and the bit index per address. Clear writes use single bits, data in the upper half only, and all ones, which separates write-one-to-clear from plain overwrite. The steering is tried with several partition values: all fields zero, mixed fields that spread the classes over all three levels, one class silenced, and all classes silenced. Causes sit in different classes on different cores, so a wrong class boundary or a wrong field position gives a wrong level on some core. Writes to the out-of-range set window and to a missing core's cause address are then read back, and the outputs are compared with a behavioural model on every cycle, which catches both missed changes and unwanted ones.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int CAUSE_W    = 16;
    localparam int NUM_CLASS  = 4;
    localparam int LVL_W      = 3;
    localparam int FIELD_W    = 2;
    localparam int DATA_W     = 32;
    localparam int CORE_IDX_W = 5;

    localparam int CAUSE_BASE = 'h100;
    localparam int SET_BASE   = 'h140;
    localparam int PART_ADDR  = 'h190;

    typedef logic [CAUSE_W-1:0]   cause_t;
    typedef logic [NUM_CLASS-1:0] class_t;
    typedef logic [LVL_W-1:0]     lvl_t;

    typedef struct packed {
        logic                  set_hit;
        logic [3:0]            set_bit;
        logic                  clr_hit;
        logic [CORE_IDX_W-1:0] clr_core;
        logic                  part_hit;
    } wr_dec_t;

    function automatic class_t fold_classes(input cause_t c);
        class_t g;
        g[0] = c[0];
        g[1] = |c[3:1];
        g[2] = |c[7:4];
        g[3] = |c[15:8];
        return g;
    endfunction

endpackage

// File: rtl/ipi_wr_decode.sv
module ipi_wr_decode #(
    parameter int ADDR_W    = 10,
    parameter int NUM_CORES = 32
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output ipi_pkg::wr_dec_t  dec
);
    localparam logic [ADDR_W-1:0] SET_LO   = ADDR_W'(ipi_pkg::SET_BASE);
    localparam logic [ADDR_W-1:0] SET_HI   = SET_LO + ADDR_W'(ipi_pkg::CAUSE_W);
    localparam logic [ADDR_W-1:0] CAUSE_LO = ADDR_W'(ipi_pkg::CAUSE_BASE);
    localparam logic [ADDR_W-1:0] CAUSE_HI = CAUSE_LO + ADDR_W'(NUM_CORES);
    localparam logic [ADDR_W-1:0] PART_A   = ADDR_W'(ipi_pkg::PART_ADDR);

    always_comb begin
        dec          = '0;
        dec.set_bit  = 4'(addr - SET_LO);
        dec.clr_core = ipi_pkg::CORE_IDX_W'(addr - CAUSE_LO);
        if (wr_en) begin
            dec.set_hit  = (addr >= SET_LO) && (addr < SET_HI);
            dec.clr_hit  = (addr >= CAUSE_LO) && (addr < CAUSE_HI);
            dec.part_hit = (addr == PART_A);
        end
    end
endmodule

// File: rtl/ipi_cause_cell.sv
module ipi_cause_cell (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_hit,
    input  logic            set_sel,
    input  logic [3:0]      set_bit,
    input  logic            clr_hit,
    input  ipi_pkg::cause_t clr_mask,
    output ipi_pkg::cause_t cause_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else if (set_hit && set_sel) begin
            cause_q <= cause_q | (ipi_pkg::cause_t'(1) << set_bit);
        end else if (clr_hit) begin
            cause_q <= cause_q & ~clr_mask;
        end
    end
endmodule

// File: rtl/ipi_steer.sv
module ipi_steer (
    input  ipi_pkg::cause_t cause,
    input  logic [7:0]      part_sel,
    output ipi_pkg::lvl_t   lvl
);
    ipi_pkg::class_t act;

    always_comb begin
        act = ipi_pkg::fold_classes(cause);
        lvl = '0;
        for (int i = 0; i < ipi_pkg::NUM_CLASS; i++) begin
            if (act[i]) begin
                case (part_sel[2*i +: 2])
                    2'd0:    lvl[0] = 1'b1;
                    2'd1:    lvl[1] = 1'b1;
                    2'd2:    lvl[2] = 1'b1;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit #(
    parameter int NUM_CORES = 32,
    parameter int ADDR_W    = 10
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                reg_wr,
    input  logic [ADDR_W-1:0]                   reg_addr,
    input  logic [ipi_pkg::DATA_W-1:0]          reg_wdata,
    output logic [ipi_pkg::DATA_W-1:0]          reg_rdata,
    output logic [NUM_CORES*ipi_pkg::LVL_W-1:0] ipi_lvl
);
    localparam logic [ADDR_W-1:0] CAUSE_LO = ADDR_W'(ipi_pkg::CAUSE_BASE);
    localparam logic [ADDR_W-1:0] CAUSE_HI = CAUSE_LO + ADDR_W'(NUM_CORES);
    localparam logic [ADDR_W-1:0] PART_A   = ADDR_W'(ipi_pkg::PART_ADDR);

    ipi_pkg::wr_dec_t             dec;
    ipi_pkg::cause_t              cause_q [NUM_CORES];
    logic [ipi_pkg::DATA_W-1:0]   part_q;
    logic [ipi_pkg::CORE_IDX_W-1:0] rd_core;

    ipi_wr_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_CORES (NUM_CORES)
    ) u_dec (
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .dec   (dec)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            part_q <= '0;
        end else if (dec.part_hit) begin
            part_q <= reg_wdata;
        end
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic clr_this;
        assign clr_this = dec.clr_hit &&
                          (dec.clr_core == ipi_pkg::CORE_IDX_W'(c));

        ipi_cause_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_hit  (dec.set_hit),
            .set_sel  (reg_wdata[c]),
            .set_bit  (dec.set_bit),
            .clr_hit  (clr_this),
            .clr_mask (reg_wdata[ipi_pkg::CAUSE_W-1:0]),
            .cause_q  (cause_q[c])
        );

        ipi_steer u_steer (
            .cause    (cause_q[c]),
            .part_sel (part_q[7:0]),
            .lvl      (ipi_lvl[c*ipi_pkg::LVL_W +: ipi_pkg::LVL_W])
        );
    end

    assign rd_core = ipi_pkg::CORE_IDX_W'(reg_addr - CAUSE_LO);

    always_comb begin
        reg_rdata = '0;
        if ((reg_addr >= CAUSE_LO) && (reg_addr < CAUSE_HI)) begin
            reg_rdata = {{(ipi_pkg::DATA_W-ipi_pkg::CAUSE_W){1'b0}}, cause_q[rd_core]};
        end else if (reg_addr == PART_A) begin
            reg_rdata = part_q;
        end
    end
endmodule

// File: rtl/ipi_unit_chk.sv
module ipi_unit_chk #(
    parameter int NUM_CORES = 32,
    parameter int ADDR_W    = 10
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                reg_wr,
    input logic [ADDR_W-1:0]                   reg_addr,
    input logic [ipi_pkg::DATA_W-1:0]          reg_wdata,
    input logic [NUM_CORES*ipi_pkg::LVL_W-1:0] ipi_lvl,
    input ipi_pkg::cause_t                     cause_first,
    input ipi_pkg::cause_t                     cause_last,
    input logic [ipi_pkg::DATA_W-1:0]          part_q
);
    localparam logic [ADDR_W-1:0] SET_LO   = ADDR_W'(ipi_pkg::SET_BASE);
    localparam logic [ADDR_W-1:0] SET_HI   = SET_LO + ADDR_W'(16);
    localparam logic [ADDR_W-1:0] DEAD_HI  = SET_LO + ADDR_W'(32);
    localparam logic [ADDR_W-1:0] CAUSE_LO = ADDR_W'(ipi_pkg::CAUSE_BASE);

    a_r1_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr >= SET_LO && reg_addr < SET_HI && reg_wdata[0])
        |=> cause_first[$past(reg_addr[3:0])]);

    a_r2_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == CAUSE_LO)
        |=> ((cause_first & $past(reg_wdata[15:0])) == '0));

    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_first == '0) |-> (ipi_lvl[2:0] == '0));

    a_r4_all_silenced: assert property (@(posedge clk) disable iff (!rst_n)
        (part_q[7:0] == 8'hFF) |-> (ipi_lvl == '0));

    a_r6_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (ipi_lvl == '0 && part_q == '0));

    a_r7_dead_window: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr >= SET_HI && reg_addr < DEAD_HI)
        |=> ($stable(cause_first) && $stable(cause_last) && $stable(part_q)));

    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(ipi_lvl));
endmodule

bind ipi_unit ipi_unit_chk #(
    .NUM_CORES (NUM_CORES),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .ipi_lvl     (ipi_lvl),
    .cause_first (cause_q[0]),
    .cause_last  (cause_q[NUM_CORES-1]),
    .part_q      (part_q)
);

// File: tb/tb_ipi_unit.sv
module tb_ipi_unit;
    localparam int NC = 32;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NC*3-1:0] ipi_lvl;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] m_cause [NC];
    logic [31:0] m_part;

    ipi_unit #(.NUM_CORES(NC), .ADDR_W(AW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ipi_lvl   (ipi_lvl)
    );

    always #4 clk = ~clk;

    function automatic logic [2:0] ref_lvl(input int c);
        logic [3:0] g;
        logic [2:0] o;
        g[0] = m_cause[c][0];
        g[1] = m_cause[c][3:1] != 0;
        g[2] = m_cause[c][7:4] != 0;
        g[3] = m_cause[c][15:8] != 0;
        o = 3'b000;
        for (int i = 0; i < 4; i++) begin
            int f;
            f = int'(m_part[2*i +: 2]);
            if (g[i] && f < 3) o[f] = 1'b1;
        end
        return o;
    endfunction

    function automatic logic [NC*3-1:0] ref_all();
        logic [NC*3-1:0] v;
        for (int c = 0; c < NC; c++) v[c*3 +: 3] = ref_lvl(c);
        return v;
    endfunction

    // R3 R4 R8: outputs compared with the model every cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (ipi_lvl !== ref_all()) begin
                errors++;
                $display("FAIL R3/R4/R8 per-cycle levels got %h exp %h", ipi_lvl, ref_all());
            end
        end
    end

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = AW'(addr);
        reg_wdata = data;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
        if (addr >= 'h140 && addr < 'h150) begin
            for (int c = 0; c < NC; c++)
                if (data[c]) m_cause[c][addr - 'h140] = 1'b1;
        end else if (addr >= 'h100 && addr < 'h100 + NC) begin
            m_cause[addr - 'h100] = m_cause[addr - 'h100] & ~data[15:0];
        end else if (addr == 'h190) begin
            m_part = data;
        end
    endtask

    task automatic rd(input int addr, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = AW'(addr);
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s read %h got %h exp %h", tag, addr, reg_rdata, exp);
        end
    endtask

    task automatic chk_lvl(input int c, input logic [2:0] exp, input string tag);
        @(negedge clk);
        #1;
        checks++;
        if (ipi_lvl[c*3 +: 3] !== exp) begin
            errors++;
            $display("FAIL %s core %0d level got %b exp %b", tag, c, ipi_lvl[c*3 +: 3], exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NC; c++) m_cause[c] = '0;
        m_part = '0;
        repeat (3) @(posedge clk);
        // R6: reset state
        rd('h100, 32'h0, "R6");
        rd('h11F, 32'h0, "R6");
        rd('h190, 32'h0, "R6");
        @(negedge clk);
        checks++;
        if (ipi_lvl !== '0) begin
            errors++;
            $display("FAIL R6 levels in reset got %h exp 0", ipi_lvl);
        end
        rst_n = 1'b1;

        // R1: sparse mask, low and high cause index
        wr('h145, 32'h8000_0005);
        rd('h100, 32'h0000_0020, "R1");
        rd('h102, 32'h0000_0020, "R1");
        rd('h11F, 32'h0000_0020, "R1");
        rd('h101, 32'h0000_0000, "R1");
        wr('h140, 32'h0000_0001);
        wr('h14F, 32'h0000_0001);
        rd('h100, 32'h0000_8021, "R1");

        // R2: write-one-to-clear
        wr('h100, 32'h0000_0020);
        rd('h100, 32'h0000_8001, "R2");
        wr('h100, 32'hFFFF_0000);
        rd('h100, 32'h0000_8001, "R2");

        // R3 R4: steering with all fields zero, then mixed
        chk_lvl(0, 3'b001, "R3");
        chk_lvl(2, 3'b001, "R3");
        wr('h190, 32'h0000_0089);
        chk_lvl(0, 3'b110, "R4");
        chk_lvl(2, 3'b001, "R4");
        wr('h142, 32'h0000_0002);
        chk_lvl(1, 3'b100, "R3");
        wr('h190, 32'h0000_00C0);
        chk_lvl(0, 3'b001, "R4");
        chk_lvl(31, 3'b001, "R4");
        wr('h190, 32'h0000_00FF);
        chk_lvl(0, 3'b000, "R4");
        chk_lvl(1, 3'b000, "R4");

        // R5: upper partition bits stored but inert
        wr('h190, 32'hABCD_1200);
        rd('h190, 32'hABCD_1200, "R5");
        chk_lvl(0, 3'b001, "R5");
        chk_lvl(1, 3'b001, "R5");

        // R7: ignored writes and unmapped reads
        wr('h150, 32'hFFFF_FFFF);
        wr('h15F, 32'hFFFF_FFFF);
        wr('h120, 32'h0000_FFFF);
        rd('h100, 32'h0000_8001, "R7");
        rd('h103, 32'h0000_0000, "R7");
        rd('h190, 32'hABCD_1200, "R7");
        rd('h150, 32'h0000_0000, "R7");
        rd('h120, 32'h0000_0000, "R7");

        // R8: idle cycles hold, then clear everything
        repeat (5) @(posedge clk);
        wr('h100, 32'h0000_FFFF);
        wr('h101, 32'h0000_FFFF);
        wr('h102, 32'h0000_FFFF);
        wr('h11F, 32'h0000_FFFF);
        chk_lvl(0, 3'b000, "R8");
        rd('h11F, 32'h0, "R2");

        repeat (3) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule